// File: doc/BRIEF.md
# Multi-Format PCM Audio Serial Transmitter

This block turns parallel stereo PCM samples into a three-wire audio stream: a bit clock, a word clock that marks the left and right halves of each frame, and one serial data line. It runs from a master clock. The bit clock is derived by division, and every frame is 64 bit clocks long, with 32 bit slots per channel. A 3-bit format input selects the placement of each sample inside its 32-slot half: I2S with one bit of delay, left-justified, right-justified with 24 or 16 significant bits, or a full 32-bit word for pass-through paths. Samples are two's complement and are shifted out most significant bit first.

Samples enter as one left/right pair per transfer on a valid/ready stream. The block holds one pending pair. `in_ready` is high only while that holding slot is empty. A transfer completes on a rising clock edge where `in_valid` and `in_ready` are both high. After the transfer, `in_ready` stays low until the next frame boundary moves the pending pair into the serializer. A producer that keeps `in_valid` high must hold its data stable until the transfer completes. If no pair is pending at a frame boundary, the next frame carries zero data and the clocks keep running. The format input is sampled only at frame boundaries. While reset is asserted, all three port outputs are low.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst_n` is low, `bclk_o`, `wclk_o` and `sdata_o` are 0. Serialization restarts with a fresh frame after reset is released.
- R2: `in_ready` is 1 exactly when no pair is pending. After a transfer it stays 0 until the next frame boundary, and a waiting producer is accepted on the first edge after that boundary.
- R3: `bclk_o` is low for `DIV_HALF` master clocks and then high for `DIV_HALF` master clocks. A frame is 64 bit-clock periods. `wclk_o` and `sdata_o` change only when `bclk_o` falls.
- R4: Format code 0, and also the unused codes 5, 6 and 7, give I2S framing. `wclk_o` is 0 for the left half and 1 for the right half. Sample bit 23 is in slot 1 of each half, bits 22..0 follow in slots 2..24, and slots 0 and 25..31 are 0.
- R5: Format code 1 gives 24-bit left-justified framing. `wclk_o` is 1 for the left half and 0 for the right half. Bit 23 is in slot 0, bit 0 is in slot 23, and slots 24..31 are 0.
- R6: Format code 2 gives 24-bit right-justified framing. `wclk_o` polarity is as in R5. Slots 0..7 are 0, bit 23 is in slot 8, and bit 0 is in slot 31.
- R7: Format code 3 gives 16-bit right-justified framing. `wclk_o` polarity is as in R5. Slots 0..15 are 0, bit 15 is in slot 16, and bit 0 is in slot 31.
- R8: Format code 4 gives 32-bit word framing. `wclk_o` polarity is as in R5. Bit 31 is in slot 0 and bit 0 is in slot 31.
- R9: Within each half, bits go out most significant first. The left sample fills slots 0..31 of the frame and the right sample fills slots 32..63. Sample bits above the selected word length are ignored.
- R10: A change of `fmt_sel` during a frame has no effect on that frame. The new code takes effect from the next frame boundary.
- R11: A frame that starts with no pair pending carries all-zero data, with the word clock pattern of the latched format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 3 | Framing code, sampled at frame boundaries |
| in_valid | input | 1 | Stereo pair offered |
| in_ready | output | 1 | Holding slot empty, pair can be accepted |
| in_left | input | 32 | Left sample, two's complement |
| in_right | input | 32 | Right sample, two's complement |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word (channel) clock |
| sdata_o | output | 1 | Serial data, changes on bclk falling edge |

## Verification
On every cycle, the assertions check four things: the outputs are low during reset, `in_ready` drops after each transfer, the word clock and data line change only when the bit clock falls, and the zero padding at the start of each 16-bit right-justified half. Only the bench's scenarios can show where each sample bit lands in each format, how the unused codes map, the exact bit-clock duty, the hand-over of a waiting producer at a frame boundary, the deferred effect of a format change, and zero frames on underrun. The bench does this by capturing whole frames on bit-clock rising edges and comparing them with frames built from the requirements.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SAMPLE_W   = 32;
  localparam int FRAME_BITS = 64;
  localparam int SLOT_BITS  = FRAME_BITS / 2;
  localparam int FIDX_W     = $clog2(FRAME_BITS);
  localparam int SIDX_W     = $clog2(SLOT_BITS);
  localparam int FMT_W      = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_I2S  = 3'd0,
    FMT_LJ24 = 3'd1,
    FMT_RJ24 = 3'd2,
    FMT_RJ16 = 3'd3,
    FMT_W32  = 3'd4
  } fmt_e;

  // Placement of a word inside one 32-slot half
  typedef struct packed {
    logic [FIDX_W-1:0] first;    // first slot carrying data
    logic [FIDX_W-1:0] count;    // number of data slots
    logic              left_hi;  // word clock level during the left half
  } slot_map_t;

  function automatic slot_map_t map_of(input logic [FMT_W-1:0] code);
    slot_map_t m;
    case (code)
      FMT_LJ24: m = '{first: 6'd0,  count: 6'd24, left_hi: 1'b1};
      FMT_RJ24: m = '{first: 6'd8,  count: 6'd24, left_hi: 1'b1};
      FMT_RJ16: m = '{first: 6'd16, count: 6'd16, left_hi: 1'b1};
      FMT_W32:  m = '{first: 6'd0,  count: 6'd32, left_hi: 1'b1};
      default:  m = '{first: 6'd1,  count: 6'd24, left_hi: 1'b0};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pcm_tx_timing.sv
module pcm_tx_timing
  import pcm_tx_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              run_q,
  output logic              bclk_raw,
  output logic [FIDX_W-1:0] bit_idx,
  output logic              frame_start
);
  localparam int DIV_W = (2 * DIV_HALF > 1) ? $clog2(2 * DIV_HALF) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(2 * DIV_HALF - 1);
  localparam logic [DIV_W-1:0]  DIV_MID  = DIV_W'(DIV_HALF);
  localparam logic [FIDX_W-1:0] BIT_LAST = FIDX_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             div_last;

  assign div_last    = (div_cnt == DIV_LAST);
  assign bclk_raw    = (div_cnt >= DIV_MID);
  assign frame_start = !run_q || (div_last && (bit_idx == BIT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      div_cnt <= '0;
      bit_idx <= '0;
    end else if (div_last) begin
      div_cnt <= '0;
      bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_holding.sv
module pcm_tx_holding
  import pcm_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                take,
  output logic                full_q,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q
);
  logic accept;

  assign in_ready = !full_q;
  assign accept   = in_valid && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (accept) begin
      full_q  <= 1'b1;
      left_q  <= in_left;
      right_q <= in_right;
    end else if (take) begin
      full_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
  import pcm_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_q,
  input  logic                frame_start,
  input  logic [FIDX_W-1:0]   bit_idx,
  input  logic [FMT_W-1:0]    fmt_sel,
  input  logic                hold_full,
  input  logic [SAMPLE_W-1:0] hold_left,
  input  logic [SAMPLE_W-1:0] hold_right,
  output logic [FMT_W-1:0]    fmt_active,
  output logic                wclk,
  output logic                sdata
);
  logic [SAMPLE_W-1:0] left_q, right_q, word;
  slot_map_t           smap;
  logic                half, in_win;
  logic [FIDX_W-1:0]   pos, rel;
  logic [SIDX_W-1:0]   pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_active <= '0;
      left_q     <= '0;
      right_q    <= '0;
    end else if (frame_start) begin
      fmt_active <= fmt_sel;
      left_q     <= hold_full ? hold_left  : '0;
      right_q    <= hold_full ? hold_right : '0;
    end
  end

  always_comb begin
    smap   = map_of(fmt_active);
    half   = bit_idx[FIDX_W-1];
    pos    = {1'b0, bit_idx[SIDX_W-1:0]};
    rel    = pos - smap.first;
    in_win = (pos >= smap.first) && (rel < smap.count);
    pick   = SIDX_W'(smap.count - 1'b1 - rel);
    word   = half ? right_q : left_q;
    wclk   = run_q && (half ^ smap.left_hi);
    sdata  = run_q && in_win && word[pick];
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FMT_W-1:0]    fmt_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                sdata_o
);
  logic                run_q, bclk_raw, frame_start, hold_full;
  logic [FIDX_W-1:0]   bit_idx;
  logic [SAMPLE_W-1:0] hold_left, hold_right;
  logic [FMT_W-1:0]    fmt_active;

  pcm_tx_timing #(.DIV_HALF(DIV_HALF)) u_timing (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .bclk_raw(bclk_raw),
    .bit_idx(bit_idx), .frame_start(frame_start)
  );

  pcm_tx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .take(frame_start),
    .full_q(hold_full), .left_q(hold_left), .right_q(hold_right)
  );

  pcm_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .frame_start(frame_start),
    .bit_idx(bit_idx), .fmt_sel(fmt_sel), .hold_full(hold_full),
    .hold_left(hold_left), .hold_right(hold_right),
    .fmt_active(fmt_active), .wclk(wclk_o), .sdata(sdata_o)
  );

  assign bclk_o = run_q && bclk_raw;
endmodule

// File: rtl/pcm_tx_checker.sv
module pcm_tx_checker
  import pcm_tx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              bclk_o,
  input logic              wclk_o,
  input logic              sdata_o,
  input logic              run_q,
  input logic [FMT_W-1:0]  fmt_q,
  input logic [FIDX_W-1:0] bit_idx
);
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!bclk_o && !wclk_o && !sdata_o));

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_wclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$stable(wclk_o)) |-> $fell(bclk_o));

  a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$stable(sdata_o)) |-> $fell(bclk_o));

  a_r7_rj16_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && fmt_q == FMT_RJ16 && bit_idx[SIDX_W-1:0] < 5'd16) |-> !sdata_o);
endmodule

bind pcm_serial_tx pcm_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o), .run_q(run_q),
  .fmt_q(fmt_active), .bit_idx(bit_idx)
);

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;
  localparam int DH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_left = '0, in_right = '0;
  logic        bclk_o, wclk_o, sdata_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pcm_serial_tx #(.DIV_HALF(DH)) i_pcm_serial_tx (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
  );

  // Frame capture on bit clock rising edges
  int        rise_cnt = 0, frames_done = 0;
  bit        prev_b = 0;
  bit [63:0] cur_sd, cur_ws, last_sd, last_ws;

  always @(negedge clk) begin
    if (!rst_n) begin
      rise_cnt = 0; frames_done = 0; prev_b = 0;
    end else begin
      if (bclk_o && !prev_b) begin
        cur_sd[rise_cnt % 64] = sdata_o;
        cur_ws[rise_cnt % 64] = wclk_o;
        if (rise_cnt % 64 == 63) begin
          last_sd = cur_sd; last_ws = cur_ws;
          frames_done = rise_cnt / 64 + 1;
        end
        rise_cnt = rise_cnt + 1;
      end
      prev_b = bclk_o;
    end
  end

  function automatic bit exp_bit(int f, logic [31:0] w, int p);
    case (f)
      1: return (p < 24) ? w[23 - p] : 1'b0;
      2: return (p >= 8) ? w[31 - p] : 1'b0;
      3: return (p >= 16) ? w[31 - p] : 1'b0;
      4: return w[31 - p];
      default: return (p >= 1 && p <= 24) ? w[24 - p] : 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_frame(int f, logic [31:0] l, logic [31:0] r, string req);
    bit [63:0] esd, ews;
    for (int k = 0; k < 64; k++) begin
      esd[k] = exp_bit(f, (k >= 32) ? r : l, k % 32);
      ews[k] = (f >= 1 && f <= 4) ? (k < 32) : (k >= 32);
    end
    check(last_sd == esd, req, "data slots", last_sd, esd);
    check(last_ws == ews, req, "word clock", last_ws, ews);
  endtask

  task automatic wait_frame(int t);
    while (frames_done <= t) @(negedge clk);
  endtask

  // Offer a pair during bit 8; returns the frame index that carries it
  task automatic push(logic [31:0] l, logic [31:0] r, output int tgt);
    @(negedge clk);
    while (rise_cnt % 64 != 9) @(negedge clk);
    tgt = rise_cnt / 64 + 1;
    check(in_ready == 1'b1, "R2", "ready while empty", in_ready, 1);
    in_valid = 1'b1; in_left = l; in_right = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(!bclk_o && !wclk_o && !sdata_o, "R1", "outputs in reset",
          {bclk_o, wclk_o, sdata_o}, 0);
    check(in_ready == 1'b1, "R2", "ready in reset", in_ready, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_clock();
    int hi = 0, lo = 0;
    @(negedge clk);
    while (!bclk_o) @(negedge clk);
    while (bclk_o) begin hi++; @(negedge clk); end
    while (!bclk_o) begin lo++; @(negedge clk); end
    check(hi == DH, "R3", "bclk high cycles", hi, DH);
    check(lo == DH, "R3", "bclk low cycles", lo, DH);
  endtask

  task automatic t_format(int code, int f_exp, logic [31:0] l, logic [31:0] r, string req);
    int t;
    fmt_sel = 3'(code);
    push(l, r, t);
    wait_frame(t);
    check_frame(f_exp, l, r, req);
  endtask

  task automatic t_backpressure();
    int t, edge_rise;
    fmt_sel = 3'd1;
    push(32'h00123456, 32'h00ABCDEF, t);
    check(in_ready == 1'b0, "R2", "ready after accept", in_ready, 0);
    in_valid = 1'b1; in_left = 32'h00800001; in_right = 32'h007FFFFE;
    while (!in_ready) @(negedge clk);
    edge_rise = rise_cnt;
    @(negedge clk);
    in_valid = 1'b0;
    check(edge_rise == 64 * t, "R2", "ready returns at boundary", edge_rise, 64 * t);
    wait_frame(t);
    check_frame(1, 32'h00123456, 32'h00ABCDEF, "R2");
    wait_frame(t + 1);
    check_frame(1, 32'h00800001, 32'h007FFFFE, "R2");
  endtask

  task automatic t_latch_underrun();
    int t;
    fmt_sel = 3'd2;
    push(32'h00C0FFEE, 32'h00F00D55, t);
    while (rise_cnt != 64 * t + 20) @(negedge clk);
    fmt_sel = 3'd1;
    wait_frame(t);
    check_frame(2, 32'h00C0FFEE, 32'h00F00D55, "R10");
    wait_frame(t + 1);
    check_frame(1, 32'h0, 32'h0, "R11");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    while (!(bclk_o && wclk_o)) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!bclk_o && !wclk_o && !sdata_o, "R1", "outputs after mid reset",
          {bclk_o, wclk_o, sdata_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_format(0, 0, 32'h00654321, 32'h00FEDCBA, "R1");
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_clock();
    t_format(0, 0, 32'h00A5C3F1, 32'hFF12345E, "R4");
    t_format(1, 1, 32'h00A5C3F1, 32'hFF12345E, "R5");
    t_format(2, 2, 32'h00800000, 32'h007FFFFF, "R6");
    t_format(3, 3, 32'h12348001, 32'hABCD7FFE, "R7");
    t_format(4, 4, 32'h8000F00F, 32'h7FFF0FF1, "R8");
    t_format(6, 0, 32'hFFFFFFFF, 32'h00000001, "R4");
    t_format(1, 1, 32'hFF000000, 32'hEE000001, "R9");
    t_backpressure();
    t_latch_underrun();
    t_mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule